// File: doc/BRIEF.md
# Extension Module Enable and Address Router

This block sits between a 24-bit bus master and a group of on-chip extension modules (two CAN controllers, a small and a large RAM, a real-time clock, a flash array and six further peripherals). It holds a module-enable register and uses it to steer every bus access to one of three places. An access can go to the select line of an enabled internal module. It can fall through to the external memory interface. Or it can receive a dead response, where the access is acknowledged, reads return zero and writes are discarded.

Fall-through to external memory is deliberately conservative. The peripheral window falls through only when no peripheral that lives in it is enabled. The flash region and the large-RAM region each fall through only when both of them are disabled. The enable register can be rewritten freely until the global extension-enable input is raised; after that it is frozen. For external accesses the block also reports which of four programmable address-select windows matched first. A per-module pin-release vector tells the pin multiplexer which modules have given up their pins to general-purpose I/O.

Routing is decoded combinationally from the address, and all routing outputs are registered. The result of an access therefore appears one clock after the strobe.

Top module: `extrt_router`

## Requirements
- R1: After reset the enable register reads 0x005, so only CAN unit 1 (bit 0) and the 2 KB RAM (bit 2) are enabled. Bit map: 0 CAN1, 1 CAN2, 2 RAM 2 KB, 3 RAM 64 KB, 4 RTC, 5 flash, 6 sync serial, 7 async serial, 8 I2C, 9 PWM, 10 misc, 11 port.
- R2: A register write while `glb_en` is 0 loads `reg_wdata` on the next edge. A write while `glb_en` is 1 leaves the register unchanged.
- R3: Addresses 0x00E000–0x00E7FF select target 2 when bit 2 is set and otherwise go external.
- R4: The peripheral window 0x00E800–0x00EFFF is divided by page. E8 is bit 6, E9 bit 7, EA bit 8, EB bit 9, EC00–EC7F bit 11, EC80–ECFF bit 10, ED bit 4, EE bit 1 and EF bit 0. An access to the page of an enabled module selects that module. If every peripheral bit (0,1,4,6–11) is 0, the access goes external. Otherwise it gets a dead response.
- R5: Addresses 0x090000–0x0EFFFF select target 5 when flash is enabled. When flash is disabled they go external if bit 3 is 0 and get a dead response if bit 3 is 1.
- R6: Addresses 0x0F0000–0x0FFFFF select target 3 when bit 3 is set. When bit 3 is clear they go external if bit 5 is 0 and get a dead response if bit 5 is 1.
- R7: Every other address goes external.
- R8: On an external access, `ext_win` is k+1 for the lowest-numbered window k (0–3) whose inclusive range [lo,hi] contains the address. If no window matches, `ext_win` is 0.
- R9: Outputs are registered one cycle after `acc_vld`. Exactly one of `mod_sel` (one bit per target, index = enable bit), `ext_acc` and `dead_acc` is active for each access, and none is active in an idle cycle.
- R10: `pin_rel[i]` is the inverse of enable bit i at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global extension enable; locks the register while high |
| reg_wr | input | 1 | Enable-register write strobe |
| reg_wdata | input | 12 | Enable-register write data |
| reg_rdata | output | 12 | Enable-register read-back |
| acc_vld | input | 1 | Bus access strobe |
| acc_addr | input | 24 | Bus access address |
| win_lo | input | 96 | Four window lower bounds, window k in bits 24k+23:24k |
| win_hi | input | 96 | Four window upper bounds, same packing |
| mod_sel | output | 12 | Registered one-hot internal target select |
| ext_acc | output | 1 | Registered external access strobe |
| ext_win | output | 3 | Registered matched window index, 0 = default |
| dead_acc | output | 1 | Registered dead response strobe |
| pin_rel | output | 12 | Per-module pin release to general-purpose I/O |

## Verification
The hardest situations to reach are the conditional fall-throughs. The access hits a disabled module, but some unrelated enable blocks the external path. Examples are a disabled CAN page while only the RTC is on, and the flash region while only the large RAM is on. The vector table reaches these by rewriting the enable register before each access with a pattern chosen to enable exactly the blocking neighbour. The lock case is reached by raising `glb_en`, attempting a write, and then reading the register back and observing routing at the ports.

// File: rtl/extrt_pkg.sv
package extrt_pkg;
    parameter int ADDR_W    = 24;
    parameter int NMOD      = 12;
    parameter int NWIN      = 4;
    localparam int WIN_IDX_W = $clog2(NWIN + 1);

    // module bit positions (software-visible)
    localparam int M_CAN1  = 0;
    localparam int M_CAN2  = 1;
    localparam int M_RAMS  = 2;
    localparam int M_RAML  = 3;
    localparam int M_RTC   = 4;
    localparam int M_FLASH = 5;
    localparam int M_SSER  = 6;
    localparam int M_ASER  = 7;
    localparam int M_I2C   = 8;
    localparam int M_PWM   = 9;
    localparam int M_MISC  = 10;
    localparam int M_PORT  = 11;

    localparam logic [NMOD-1:0] PERIPH_MASK = 12'hFD3;
    localparam logic [NMOD-1:0] EN_RESET    = 12'h005;

    typedef struct packed {
        logic [NMOD-1:0]      sel;
        logic                 ext;
        logic                 dead;
        logic [WIN_IDX_W-1:0] win;
    } route_t;
endpackage

// File: rtl/extrt_enable_reg.sv
module extrt_enable_reg #(
    parameter int              W   = 12,
    parameter logic [W-1:0]    RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         glb_en,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_q
);
    logic [W-1:0] en_d;

    always_comb begin
        en_d = en_q;
        if (wr && !glb_en)
            en_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= RST;
        else        en_q <= en_d;
    end

    // R2: frozen while global enable is high
    p_locked_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && glb_en) |=> $stable(en_q));
    // R2: open write lands next cycle
    p_open_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !glb_en) |=> (en_q == $past(wdata)));
endmodule

// File: rtl/extrt_win_match.sv
module extrt_win_match #(
    parameter int AW    = 24,
    parameter int NW    = 4,
    parameter int IDX_W = 3
) (
    input  logic [AW-1:0]    addr,
    input  logic [NW*AW-1:0] lo,
    input  logic [NW*AW-1:0] hi,
    output logic [IDX_W-1:0] idx
);
    logic [NW-1:0] hit;

    for (genvar k = 0; k < NW; k++) begin : g_win
        assign hit[k] = (addr >= lo[k*AW +: AW]) && (addr <= hi[k*AW +: AW]);
    end

    always_comb begin
        idx = '0;
        for (int k = NW - 1; k >= 0; k--) begin
            if (hit[k])
                idx = IDX_W'(k + 1);
        end
    end
endmodule

// File: rtl/extrt_decode.sv
module extrt_decode
    import extrt_pkg::*;
(
    input  logic              vld,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NMOD-1:0]   en,
    output logic [NMOD-1:0]   sel,
    output logic              ext,
    output logic              dead
);
    logic in_low, in_rams, in_shared, in_flash, in_raml;
    logic periph_off;
    int   owner;

    always_comb begin
        in_low    = (addr[ADDR_W-1:16] == '0);
        in_rams   = in_low && (addr[15:11] == 5'b11100);
        in_shared = in_low && (addr[15:11] == 5'b11101);
        in_flash  = (addr >= ADDR_W'(24'h090000)) && (addr <= ADDR_W'(24'h0EFFFF));
        in_raml   = (addr[ADDR_W-1:16] == 8'h0F);
        periph_off = ((en & PERIPH_MASK) == '0);

        case (addr[15:8])
            8'hE8:   owner = M_SSER;
            8'hE9:   owner = M_ASER;
            8'hEA:   owner = M_I2C;
            8'hEB:   owner = M_PWM;
            8'hEC:   owner = addr[7] ? M_MISC : M_PORT;
            8'hED:   owner = M_RTC;
            8'hEE:   owner = M_CAN2;
            default: owner = M_CAN1;
        endcase

        sel  = '0;
        ext  = 1'b0;
        dead = 1'b0;
        if (vld) begin
            if (in_rams) begin
                if (en[M_RAMS]) sel[M_RAMS] = 1'b1;
                else            ext = 1'b1;
            end else if (in_shared) begin
                if (en[owner])       sel[owner] = 1'b1;
                else if (periph_off) ext = 1'b1;
                else                 dead = 1'b1;
            end else if (in_flash) begin
                if (en[M_FLASH])     sel[M_FLASH] = 1'b1;
                else if (!en[M_RAML]) ext = 1'b1;
                else                 dead = 1'b1;
            end else if (in_raml) begin
                if (en[M_RAML])       sel[M_RAML] = 1'b1;
                else if (!en[M_FLASH]) ext = 1'b1;
                else                  dead = 1'b1;
            end else begin
                ext = 1'b1;
            end
        end
    end
endmodule

// File: rtl/extrt_router.sv
module extrt_router
    import extrt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   glb_en,
    input  logic                   reg_wr,
    input  logic [NMOD-1:0]        reg_wdata,
    output logic [NMOD-1:0]        reg_rdata,
    input  logic                   acc_vld,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic [NWIN*ADDR_W-1:0] win_lo,
    input  logic [NWIN*ADDR_W-1:0] win_hi,
    output logic [NMOD-1:0]        mod_sel,
    output logic                   ext_acc,
    output logic [WIN_IDX_W-1:0]   ext_win,
    output logic                   dead_acc,
    output logic [NMOD-1:0]        pin_rel
);
    logic [NMOD-1:0]      en_q;
    logic [NMOD-1:0]      dec_sel;
    logic                 dec_ext, dec_dead;
    logic [WIN_IDX_W-1:0] win_idx;
    route_t               rt_d, rt_q;

    extrt_enable_reg #(.W(NMOD), .RST(EN_RESET)) u_en (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en),
        .wr(reg_wr), .wdata(reg_wdata), .en_q(en_q)
    );

    extrt_decode u_dec (
        .vld(acc_vld), .addr(acc_addr), .en(en_q),
        .sel(dec_sel), .ext(dec_ext), .dead(dec_dead)
    );

    extrt_win_match #(.AW(ADDR_W), .NW(NWIN), .IDX_W(WIN_IDX_W)) u_win (
        .addr(acc_addr), .lo(win_lo), .hi(win_hi), .idx(win_idx)
    );

    always_comb begin
        rt_d      = '0;
        rt_d.sel  = dec_sel;
        rt_d.ext  = dec_ext;
        rt_d.dead = dec_dead;
        rt_d.win  = dec_ext ? win_idx : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rt_q <= '0;
        else        rt_q <= rt_d;
    end

    assign mod_sel   = rt_q.sel;
    assign ext_acc   = rt_q.ext;
    assign ext_win   = rt_q.win;
    assign dead_acc  = rt_q.dead;
    assign reg_rdata = en_q;
    assign pin_rel   = ~en_q;

    // R9: at most one outcome at a time
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mod_sel, ext_acc, dead_acc}));
    // R9: each access produces exactly one outcome next cycle
    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld |=> ($countones({mod_sel, ext_acc, dead_acc}) == 1));
    // R9: idle cycle produces nothing
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_vld |=> ({mod_sel, ext_acc, dead_acc} == '0));
    // R4: only enabled modules are ever selected
    p_sel_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld |=> ((mod_sel & ~$past(en_q)) == '0));
    // R8: window index within range and zero when not external
    p_win_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_win <= WIN_IDX_W'(NWIN)) && (ext_acc || ext_win == '0));
endmodule

// File: tb/extrt_router_test.sv
module extrt_router_test;
    import extrt_pkg::*;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   glb_en = 1'b0;
    logic                   reg_wr = 1'b0;
    logic [NMOD-1:0]        reg_wdata = '0;
    logic [NMOD-1:0]        reg_rdata;
    logic                   acc_vld = 1'b0;
    logic [ADDR_W-1:0]      acc_addr = '0;
    logic [NWIN*ADDR_W-1:0] win_lo, win_hi;
    logic [NMOD-1:0]        mod_sel;
    logic                   ext_acc;
    logic [WIN_IDX_W-1:0]   ext_win;
    logic                   dead_acc;
    logic [NMOD-1:0]        pin_rel;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk; // 250 MHz

    extrt_router uut (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_vld(acc_vld), .acc_addr(acc_addr),
        .win_lo(win_lo), .win_hi(win_hi),
        .mod_sel(mod_sel), .ext_acc(ext_acc), .ext_win(ext_win),
        .dead_acc(dead_acc), .pin_rel(pin_rel)
    );

    // windows: 0 100000-1FFFFF, 1 0E0000-0FFFFF, 2 000000-00FFFF, 3 0F8000-0FFFFF
    assign win_lo = {24'h0F8000, 24'h000000, 24'h0E0000, 24'h100000};
    assign win_hi = {24'h0FFFFF, 24'h00FFFF, 24'h0FFFFF, 24'h1FFFFF};

    // {en[11:0], addr[23:0], sel[11:0], ext, dead, win[2:0]}
    localparam int NV = 18;
    localparam logic [52:0] VEC [NV] = '{
        {12'h005, 24'h00E100, 12'h004, 1'b0, 1'b0, 3'd0}, // R3 small RAM on
        {12'h000, 24'h00E100, 12'h000, 1'b1, 1'b0, 3'd3}, // R3 small RAM off
        {12'h000, 24'h00EF10, 12'h000, 1'b1, 1'b0, 3'd3}, // R4 all periph off
        {12'h001, 24'h00EF10, 12'h001, 1'b0, 1'b0, 3'd0}, // R4 CAN1 on
        {12'h001, 24'h00EE10, 12'h000, 1'b0, 1'b1, 3'd0}, // R4 CAN2 off, CAN1 blocks
        {12'h010, 24'h00EF10, 12'h000, 1'b0, 1'b1, 3'd0}, // R4 RTC blocks CAN page
        {12'h010, 24'h00ED40, 12'h010, 1'b0, 1'b0, 3'd0}, // R4 RTC on
        {12'h800, 24'h00EC10, 12'h800, 1'b0, 1'b0, 3'd0}, // R4 port half page
        {12'h800, 24'h00EC90, 12'h000, 1'b0, 1'b1, 3'd0}, // R4 misc off, port blocks
        {12'h000, 24'h0A0000, 12'h000, 1'b1, 1'b0, 3'd0}, // R5 fall-through, no window
        {12'h008, 24'h0A0000, 12'h000, 1'b0, 1'b1, 3'd0}, // R5 big RAM blocks
        {12'h020, 24'h0A0000, 12'h020, 1'b0, 1'b0, 3'd0}, // R5 flash on
        {12'h020, 24'h0F8000, 12'h000, 1'b0, 1'b1, 3'd0}, // R6 flash blocks
        {12'h000, 24'h0F9000, 12'h000, 1'b1, 1'b0, 3'd2}, // R6 + R8 priority over window 3
        {12'h008, 24'h0F9000, 12'h008, 1'b0, 1'b0, 3'd0}, // R6 big RAM on
        {12'h000, 24'h123456, 12'h000, 1'b1, 1'b0, 3'd1}, // R7 + R8 window 0
        {12'hFFF, 24'h200000, 12'h000, 1'b1, 1'b0, 3'd0}, // R7 + R8 default
        {12'h000, 24'h0E0000, 12'h000, 1'b1, 1'b0, 3'd2}  // R5 + R8 window 1 edge
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_en(input logic [NMOD-1:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic access(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        acc_vld = 1'b1; acc_addr = a;
        @(negedge clk);
        acc_vld = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset value", 32'(reg_rdata), 32'h005);
        chk("R9 reset outputs", 32'({mod_sel, ext_acc, dead_acc, ext_win}), 32'h0);
        chk("R10 reset pin release", 32'(pin_rel), 32'hFFA);

        for (int i = 0; i < NV; i++) begin
            wr_en(VEC[i][52:41]);
            chk("R2 write", 32'(reg_rdata), 32'(VEC[i][52:41]));
            access(VEC[i][40:17]);
            chk($sformatf("R3-7 vec %0d sel", i), 32'(mod_sel), 32'(VEC[i][16:5]));
            chk($sformatf("R9 vec %0d ext", i), 32'(ext_acc), 32'(VEC[i][4]));
            chk($sformatf("R9 vec %0d dead", i), 32'(dead_acc), 32'(VEC[i][3]));
            chk($sformatf("R8 vec %0d win", i), 32'(ext_win), 32'(VEC[i][2:0]));
        end

        // R9 idle cycle: nothing asserted
        @(negedge clk);
        chk("R9 idle", 32'({mod_sel, ext_acc, dead_acc}), 32'h0);

        // R10 pin release follows enables
        wr_en(12'h001);
        chk("R10 CAN1 keeps pins", 32'(pin_rel), 32'hFFE);

        // R2 lock: write ignored while glb_en high
        glb_en = 1'b1;
        wr_en(12'h000);
        chk("R2 locked readback", 32'(reg_rdata), 32'h001);
        access(24'h00EF00);
        chk("R2 locked routing keeps CAN1", 32'(mod_sel), 32'h001);
        glb_en = 1'b0;
        wr_en(12'h000);
        chk("R2 unlocked write", 32'(reg_rdata), 32'h000);
        access(24'h00EF00);
        chk("R4 after unlock goes external", 32'(ext_acc), 32'h1);

        // R4 boundary: first and last address of the peripheral window
        wr_en(12'h040);
        access(24'h00E800);
        chk("R4 low edge sync serial", 32'(mod_sel), 32'h040);
        access(24'h00EFFF);
        chk("R4 top edge blocked", 32'(dead_acc), 32'h1);
        access(24'h00E7FF);
        chk("R3 top edge small RAM off", 32'(ext_acc), 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule